// File: doc/BRIEF.md
# Serial PHY Tuning Writer

This block turns one parallel tuning command into a series of single-bit writes into the internal tuning space of an analog PHY. A command has a start address, a data word, a bit count and the index of the target PHY. The block walks through the word starting at the least significant bit. For every bit it drives a 16-bit control image: an address field, a data bit and one strobe bit for each PHY. The strobe is pulsed to commit each bit into the PHY.

The requester raises `cmd_valid` for one cycle while the block is idle. The block then holds `busy` until the last strobe has dropped and pulses `done`. The `zero_first` input selects the newer register variant, in which the whole control image is cleared once before the first bit. The PHY at the receiving end samples the control image directly. Which of several requesters owns the block is decided outside it.

Top module: `phy_tune_writer`

## Requirements
- R1: After reset `ctl_q` is 0, `busy` is 0 and `done` is 0.
- R2: For bit i of a command, `ctl_q[15:8]` holds (start address + i) modulo 256 while that bit is committed.
- R3: The data bit sits at `ctl_q[7]`. Bits are sent least significant first, so bit i of the command carries `cmd_data[i]`.
- R4: The strobe for PHY n is `ctl_q[2*n]`. Only that strobe among the even bits 6:0 is ever high during a command to PHY n.
- R5: Each bit runs in four steps: load the address, set the data bit with the strobe low, raise the strobe, lower the strobe. `ctl_q[15:7]` does not change while the strobe is rising, high or falling.
- R6: Each strobe stays high for exactly `STROBE_HI` cycles.
- R7: With `zero_first`=1, `ctl_q` is 0 two cycles after the accept edge. With `zero_first`=0, the address field is already loaded in that cycle and `ctl_q[7:0]` keeps its earlier value.
- R8: `busy` rises only on the cycle after an accepted command. It stays high for len*(`STROBE_HI`+3) cycles, plus 1 when `zero_first`=1.
- R9: `done` is a one-cycle pulse in the cycle right after `busy` falls. It is never high together with `busy`.
- R10: `cmd_valid` is ignored while `busy` is high. The running command completes unchanged, and no second command follows it.
- R11: A bit count of 0 gives `done` in the next cycle. `busy` stays low and `ctl_q` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, accepted while idle |
| cmd_addr | input | 8 | Tuning address of the first bit |
| cmd_data | input | DATA_W (32) | Bits to send, LSB first |
| cmd_len | input | CNT_W (6) | Number of bits to send |
| cmd_phy | input | IDX_W (2) | Target PHY index |
| zero_first | input | 1 | 1: clear the control image before the first bit |
| ctl_q | output | 16 | Control image driven toward the PHYs |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with a 32-bit data word, four PHYs and a strobe high time of 2 cycles. The two-cycle strobe shows whether the high-time counter is honoured rather than a fixed single-cycle pulse. With the full word width a 32-bit command can start near the top of the address space, so the address wrap past 0xFF is exercised. All four strobe positions are covered. A second request during a command, a zero-length command and both settings of the pre-clear variant are mixed in with random commands.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;
  localparam int CTL_W    = 16;
  localparam int TADDR_W  = 8;
  localparam int ADDR_LSB = 8;
  localparam int DBIT_POS = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_ADDR,
    ST_DATA,
    ST_HIGH,
    ST_LOW
  } tune_st_e;
endpackage

// File: rtl/phy_tune_seq.sv
module phy_tune_seq
  import phy_tune_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int STROBE_HI = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CNT_W-1:0] cmd_len,
  input  logic             zero_first,
  output tune_st_e         state,
  output logic             load,
  output logic             step,
  output logic             busy,
  output logic             done
);
  localparam int HI_W = (STROBE_HI > 1) ? $clog2(STROBE_HI) : 1;

  tune_st_e         st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic             done_q, done_d;

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    hi_d   = hi_q;
    done_d = 1'b0;
    load   = 1'b0;
    step   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          if (cmd_len == '0) begin
            done_d = 1'b1;
          end else begin
            load  = 1'b1;
            rem_d = cmd_len;
            st_d  = zero_first ? ST_CLEAR : ST_ADDR;
          end
        end
      end
      ST_CLEAR: st_d = ST_ADDR;
      ST_ADDR:  st_d = ST_DATA;
      ST_DATA: begin
        hi_d = HI_W'(STROBE_HI - 1);
        st_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (hi_q == '0) st_d = ST_LOW;
        else            hi_d = hi_q - 1'b1;
      end
      ST_LOW: begin
        if (rem_q == CNT_W'(1)) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          step  = 1'b1;
          rem_d = rem_q - 1'b1;
          st_d  = ST_ADDR;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      hi_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      hi_q   <= hi_d;
      done_q <= done_d;
    end
  end

  assign state = st_q;
  assign busy  = (st_q != ST_IDLE);
  assign done  = done_q;
endmodule

// File: rtl/phy_tune_shift.sv
module phy_tune_shift
  import phy_tune_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [TADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0]  cmd_data,
  input  logic [IDX_W-1:0]   cmd_phy,
  output logic [TADDR_W-1:0] cur_addr,
  output logic               cur_bit,
  output logic [IDX_W-1:0]   phy_sel
);
  logic [TADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0]  word_q, word_d;
  logic [IDX_W-1:0]   phy_q, phy_d;
  logic               en;

  assign en = load | step;

  always_comb begin
    addr_d = addr_q;
    word_d = word_q;
    phy_d  = phy_q;
    if (load) begin
      addr_d = cmd_addr;
      word_d = cmd_data;
      phy_d  = cmd_phy;
    end else if (step) begin
      addr_d = addr_q + 1'b1;
      word_d = word_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      word_q <= '0;
      phy_q  <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      word_q <= word_d;
      phy_q  <= phy_d;
    end
  end

  assign cur_addr = addr_q;
  assign cur_bit  = word_q[0];
  assign phy_sel  = phy_q;
endmodule

// File: rtl/phy_tune_ctlreg.sv
module phy_tune_ctlreg
  import phy_tune_pkg::*;
#(
  parameter int NUM_PHY = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tune_st_e           state,
  input  logic [TADDR_W-1:0] cur_addr,
  input  logic               cur_bit,
  input  logic [IDX_W-1:0]   phy_sel,
  output logic [CTL_W-1:0]   ctl_q
);
  logic [NUM_PHY-1:0] phy_hit;
  logic [CTL_W-1:0]   stb_mask;
  logic [CTL_W-1:0]   ctl_d;
  logic               en;

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_phy
    assign phy_hit[g] = (phy_sel == IDX_W'(g));
  end

  always_comb begin
    stb_mask = '0;
    for (int k = 0; k < NUM_PHY; k++) stb_mask[2*k] = phy_hit[k];
  end

  assign en = (state != ST_IDLE);

  always_comb begin
    ctl_d = ctl_q;
    case (state)
      ST_CLEAR: ctl_d = '0;
      ST_ADDR:  ctl_d[ADDR_LSB +: TADDR_W] = cur_addr;
      ST_DATA: begin
        ctl_d[DBIT_POS] = cur_bit;
        ctl_d           = ctl_d & ~stb_mask;
      end
      ST_HIGH:  ctl_d = ctl_q | stb_mask;
      ST_LOW:   ctl_d = ctl_q & ~stb_mask;
      default:  ctl_d = ctl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (en) ctl_q <= ctl_d;
  end
endmodule

// File: rtl/phy_tune_writer.sv
module phy_tune_writer
  import phy_tune_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_PHY   = 4,
  parameter int STROBE_HI = 1,
  localparam int CNT_W    = $clog2(DATA_W + 1),
  localparam int IDX_W    = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [CNT_W-1:0]  cmd_len,
  input  logic [IDX_W-1:0]  cmd_phy,
  input  logic              zero_first,
  output logic [15:0]       ctl_q,
  output logic              busy,
  output logic              done
);
  tune_st_e           state;
  logic               load, step;
  logic [TADDR_W-1:0] cur_addr;
  logic               cur_bit;
  logic [IDX_W-1:0]   phy_sel;

  phy_tune_seq #(.CNT_W(CNT_W), .STROBE_HI(STROBE_HI)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_len(cmd_len),
    .zero_first(zero_first), .state(state), .load(load), .step(step),
    .busy(busy), .done(done)
  );

  phy_tune_shift #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_phy(cmd_phy),
    .cur_addr(cur_addr), .cur_bit(cur_bit), .phy_sel(phy_sel)
  );

  phy_tune_ctlreg #(.NUM_PHY(NUM_PHY), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .state(state), .cur_addr(cur_addr),
    .cur_bit(cur_bit), .phy_sel(phy_sel), .ctl_q(ctl_q)
  );
endmodule

// File: rtl/phy_tune_checker.sv
module phy_tune_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [CNT_W-1:0] cmd_len,
  input logic [15:0]      ctl_q,
  input logic             busy,
  input logic             done
);
  logic [3:0] stb;
  logic       stb_any;
  assign stb     = {ctl_q[6], ctl_q[4], ctl_q[2], ctl_q[0]};
  assign stb_any = |stb;

  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

  assert_rise_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_any) |-> $stable(ctl_q[15:7]));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_any && $past(stb_any)) |-> $stable(ctl_q[15:7]));

  assert_fall_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb_any) |-> $stable(ctl_q[15:7]));

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_len_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_len == '0) |=> (done && !busy));
endmodule

bind phy_tune_writer phy_tune_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_len(cmd_len),
  .ctl_q(ctl_q), .busy(busy), .done(done)
);

// File: tb/tb_phy_tune_writer.sv
module tb_phy_tune_writer;
  localparam int DATA_W = 32;
  localparam int NPHY   = 4;
  localparam int HI     = 2;
  localparam int CW     = $clog2(DATA_W + 1);

  logic              clk, rst_n, cmd_valid, zero_first;
  logic [7:0]        cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic [CW-1:0]     cmd_len;
  logic [1:0]        cmd_phy;
  logic [15:0]       ctl_q;
  logic              busy, done;

  int n_chk, n_fail;
  logic [7:0] ev_addr [64];
  logic       ev_bit  [64];
  logic [6:0] ev_stb  [64];
  int         ev_hi   [64];

  phy_tune_writer #(.DATA_W(DATA_W), .NUM_PHY(NPHY), .STROBE_HI(HI)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_len(cmd_len), .cmd_phy(cmd_phy),
    .zero_first(zero_first), .ctl_q(ctl_q), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_busy(input int len, input logic zf);
    return (len == 0) ? 0 : len * (HI + 3) + (zf ? 1 : 0);
  endfunction

  task automatic run_cmd(input logic [7:0] a, input logic [DATA_W-1:0] d,
                         input int len, input logic [1:0] p, input logic zf,
                         input logic inject);
    logic [15:0] prev;
    logic [6:0]  s, ps;
    int cyc, bcnt, evn, hi, dcyc;
    logic got;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_data = d; cmd_len = CW'(len);
    cmd_phy = p; zero_first = zf;
    prev = ctl_q; ps = 7'h0; cyc = 0; bcnt = 0; evn = 0; hi = 0;
    got = 1'b0; dcyc = 0;
    while (!got && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) cmd_valid = 1'b0;
      if (busy) bcnt++;
      if (done) begin got = 1'b1; dcyc = cyc; end
      if (cyc == 2 && len > 0) begin
        if (zf) chk(ctl_q == 16'h0, "R7", ctl_q, 0);
        else    chk(ctl_q == {a, prev[7:0]}, "R7", ctl_q, {a, prev[7:0]});
      end
      s = ctl_q[6:0] & 7'h55;
      if (s != 0 && ps == 0) begin
        if (evn < 64) begin
          ev_addr[evn] = ctl_q[15:8]; ev_bit[evn] = ctl_q[7]; ev_stb[evn] = s;
        end
        evn++; hi = 1;
      end else if (s != 0) hi++;
      if (s == 0 && ps != 0 && evn > 0 && evn <= 64) ev_hi[evn-1] = hi;
      ps = s;
      if (inject && cyc == 4) begin
        cmd_valid = 1'b1; cmd_addr = a ^ 8'h55; cmd_data = ~d; cmd_len = CW'(3);
      end
      if (inject && cyc == 5) cmd_valid = 1'b0;
    end
    chk(got, "R9 done seen", got, 1);
    chk(bcnt == exp_busy(len, zf), "R8 busy length", bcnt, exp_busy(len, zf));
    chk(dcyc == bcnt + 1, "R9 done after busy", dcyc, bcnt + 1);
    chk(evn == len, inject ? "R10 strobe count" : "R2 strobe count", evn, len);
    for (int i = 0; i < len && i < evn && i < 64; i++) begin
      chk(ev_addr[i] == 8'(a + i), "R2 address", ev_addr[i], 8'(a + i));
      chk(ev_bit[i] == d[i], "R3 data bit", ev_bit[i], d[i]);
      chk(ev_stb[i] == 7'(1 << (2 * p)), "R4 strobe position", ev_stb[i], 1 << (2 * p));
      chk(ev_hi[i] == HI, "R6 strobe high time", ev_hi[i], HI);
    end
    if (len == 0) chk(ctl_q == prev, "R11 image unchanged", ctl_q, prev);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    if (inject) begin
      repeat (3) @(negedge clk);
      chk(!busy, "R10 no second command", busy, 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd4711));
    cmd_valid = 0; cmd_addr = 0; cmd_data = 0; cmd_len = 0; cmd_phy = 0; zero_first = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(ctl_q == 0, "R1 ctl", ctl_q, 0);
    chk(!busy, "R1 busy", busy, 0);
    chk(!done, "R1 done", done, 0);
    rst_n = 1;
    @(negedge clk);
    run_cmd(8'h0C, 32'h1, 1, 2'd0, 1'b1, 1'b0);
    run_cmd(8'h20, 32'h14, 5, 2'd1, 1'b0, 1'b0);
    run_cmd(8'h2A, 32'h3, 2, 2'd2, 1'b1, 1'b0);
    run_cmd(8'h3C, 32'h2, 2, 2'd3, 1'b0, 1'b0);
    run_cmd(8'hF0, 32'hA5C3_96E1, 32, 2'd1, 1'b0, 1'b0);
    run_cmd(8'h11, 32'hFFFF_FFFF, 0, 2'd2, 1'b1, 1'b0);
    run_cmd(8'h40, 32'h0000_00B7, 8, 2'd0, 1'b0, 1'b1);
    for (int n = 0; n < 30; n++) begin
      run_cmd(8'($urandom), $urandom, int'($urandom_range(0, DATA_W)),
              2'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule